// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block judges whether a phase-locked loop has settled. It watches the phase-frequency detector once per comparison. On each comparison a strobe arrives with an unsigned phase-error magnitude, given as a count of fast-clock ticks. A run of small errors declares lock. A mode input picks how long that run must be: a short run of three or a long run of five.

Once the flag is set, a second and larger threshold holds it. Errors between the two thresholds leave the lock in place. Only an error above the larger threshold drops it. After a drop, acquisition starts again from an empty run.

A three-bit select drives a small status multiplexer. It can show the lock flag, its inverse, the verdict on the latest comparison, or one of two pass-through tick inputs from the reference and feedback dividers.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst` is high, and after it falls, `locked` is 0, `lastGood` and `lastBad` are 0, and the good-run count is empty. A full run of good comparisons is then needed to lock.
- R2: With `precise` = 0, `locked` goes to 1 on the clock edge that takes the third consecutive good strobe, and not earlier.
- R3: With `precise` = 1, `locked` goes to 1 on the clock edge that takes the fifth consecutive good strobe, and not earlier.
- R4: A strobe counts as good only when `phaseErr` < ACQ_TICKS (default 15). A value equal to ACQ_TICKS is not good.
- R5: While locked, a strobe with `phaseErr` > REL_TICKS (default 25) clears `locked` on that edge. A value equal to REL_TICKS keeps the lock.
- R6: Before lock, a strobe that is not good empties the run, so a full new run is required.
- R7: Cycles with `sampleValid` = 0 neither add to the run nor break it, and never change `locked`.
- R8: While locked, an error in the band from ACQ_TICKS to REL_TICKS keeps the lock. After the lock is lost, re-acquisition needs a complete fresh run.
- R9: `statusOut` is selected by `muxSel` as follows: 0 gives 0; 1 gives `locked`; 2 gives the inverse of `locked`; 3 gives lastGood; 4 gives lastBad; 5 gives `refTick`; 6 gives `fbTick`; 7 gives 1.
- R10: lastGood and lastBad are registered on each strobe. lastGood records `phaseErr` < ACQ_TICKS. lastBad records `phaseErr` > REL_TICKS. Both hold between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | One-cycle strobe per detector comparison |
| phaseErr | input | ERR_W | Unsigned phase-error magnitude in ticks |
| precise | input | 1 | 0: three-sample run, 1: five-sample run |
| muxSel | input | 3 | Status output source select |
| refTick | input | 1 | Reference divider tick, passed to mux |
| fbTick | input | 1 | Feedback divider tick, passed to mux |
| locked | output | 1 | Active-high lock flag |
| statusOut | output | 1 | Selected status signal |

## Verification
Acquisition is driven with unbroken runs of small errors in both modes. The check confirms that the flag rises on exactly the third or fifth strobe, which separates an off-by-one run length from a correct one. Errors exactly at each threshold (14 against 15, and 25 against 26) separate strict comparisons from inclusive ones. A bad strobe in the middle of a run shows whether the run is emptied or merely paused. Idle gaps inside a run show that only strobed cycles count. A mid-band error while locked, followed by a drop and a fresh run, separates hysteresis from a single threshold and shows that no stale count survives. Every multiplexer code is then selected against known status values.

// File: rtl/pll_lock_detect_pkg.sv
package pll_lock_detect_pkg;
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic sampleTake;
  } ldCtrl_t;

  typedef enum logic [2:0] {
    SEL_ZERO     = 3'd0,
    SEL_LOCK     = 3'd1,
    SEL_UNLOCK   = 3'd2,
    SEL_LASTGOOD = 3'd3,
    SEL_LASTBAD  = 3'd4,
    SEL_REF      = 3'd5,
    SEL_FB       = 3'd6,
    SEL_ONE      = 3'd7
  } statusSel_e;
endpackage

// File: rtl/pll_lock_datapath.sv
module pll_lock_datapath
  import pll_lock_detect_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int ACQ_TICKS   = 15,
  parameter int REL_TICKS   = 25,
  parameter int FAST_RUN    = 3,
  parameter int PRECISE_RUN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  ldCtrl_t          ctrl,
  input  logic [ERR_W-1:0] phaseErr,
  input  logic             precise,
  output logic             isGood,
  output logic             isBad,
  output logic             runComplete,
  output logic             lastGood,
  output logic             lastBad
);
  localparam int MAX_RUN = (FAST_RUN > PRECISE_RUN) ? FAST_RUN : PRECISE_RUN;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);
  localparam logic [ERR_W:0] ACQ_LIM = ERR_W'(ACQ_TICKS);
  localparam logic [ERR_W:0] REL_LIM = ERR_W'(REL_TICKS);
  localparam logic [CNT_W:0] FAST_NEED = (CNT_W+1)'(FAST_RUN);
  localparam logic [CNT_W:0] PREC_NEED = (CNT_W+1)'(PRECISE_RUN);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W:0]   needRun;
  logic [CNT_W:0]   nextRun;

  assign isGood  = {1'b0, phaseErr} < ACQ_LIM;
  assign isBad   = {1'b0, phaseErr} > REL_LIM;
  assign needRun = precise ? PREC_NEED : FAST_NEED;
  assign nextRun = {1'b0, runCnt} + 1'b1;
  assign runComplete = nextRun >= needRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (ctrl.cntClr) begin
      runCnt <= '0;
    end else if (ctrl.cntInc) begin
      runCnt <= nextRun[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastGood <= 1'b0;
      lastBad  <= 1'b0;
    end else if (ctrl.sampleTake) begin
      lastGood <= isGood;
      lastBad  <= isBad;
    end
  end
endmodule

// File: rtl/pll_lock_control.sv
module pll_lock_control
  import pll_lock_detect_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleValid,
  input  logic    isGood,
  input  logic    isBad,
  input  logic    runComplete,
  output ldCtrl_t ctrl,
  output logic    locked
);
  logic lockSet;
  logic lockDrop;

  assign lockSet  = sampleValid && !locked && isGood && runComplete;
  assign lockDrop = sampleValid && locked && isBad;

  always_comb begin
    ctrl            = '0;
    ctrl.sampleTake = sampleValid;
    if (sampleValid) begin
      if (!locked) begin
        ctrl.cntInc = isGood && !runComplete;
        ctrl.cntClr = !isGood || runComplete;
      end else begin
        ctrl.cntClr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
    end else if (lockSet) begin
      locked <= 1'b1;
    end else if (lockDrop) begin
      locked <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_status_mux.sv
module pll_status_mux
  import pll_lock_detect_pkg::*;
(
  input  logic [2:0] muxSel,
  input  logic       locked,
  input  logic       lastGood,
  input  logic       lastBad,
  input  logic       refTick,
  input  logic       fbTick,
  output logic       statusOut
);
  always_comb begin
    unique case (statusSel_e'(muxSel))
      SEL_ZERO:     statusOut = 1'b0;
      SEL_LOCK:     statusOut = locked;
      SEL_UNLOCK:   statusOut = !locked;
      SEL_LASTGOOD: statusOut = lastGood;
      SEL_LASTBAD:  statusOut = lastBad;
      SEL_REF:      statusOut = refTick;
      SEL_FB:       statusOut = fbTick;
      SEL_ONE:      statusOut = 1'b1;
      default:      statusOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_detect_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int ACQ_TICKS   = 15,
  parameter int REL_TICKS   = 25,
  parameter int FAST_RUN    = 3,
  parameter int PRECISE_RUN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic [ERR_W-1:0] phaseErr,
  input  logic             precise,
  input  logic [2:0]       muxSel,
  input  logic             refTick,
  input  logic             fbTick,
  output logic             locked,
  output logic             statusOut
);
  ldCtrl_t ctrl;
  logic isGood, isBad, runComplete, lastGood, lastBad;

  pll_lock_datapath #(
    .ERR_W(ERR_W), .ACQ_TICKS(ACQ_TICKS), .REL_TICKS(REL_TICKS),
    .FAST_RUN(FAST_RUN), .PRECISE_RUN(PRECISE_RUN)
  ) uDatapath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .phaseErr(phaseErr), .precise(precise),
    .isGood(isGood), .isBad(isBad), .runComplete(runComplete),
    .lastGood(lastGood), .lastBad(lastBad)
  );

  pll_lock_control uControl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .isGood(isGood),
    .isBad(isBad), .runComplete(runComplete), .ctrl(ctrl), .locked(locked)
  );

  pll_status_mux uMux (
    .muxSel(muxSel), .locked(locked), .lastGood(lastGood), .lastBad(lastBad),
    .refTick(refTick), .fbTick(fbTick), .statusOut(statusOut)
  );
endmodule

// File: rtl/pll_lock_detect_checker.sv
module pll_lock_detect_checker #(
  parameter int ERR_W     = 8,
  parameter int ACQ_TICKS = 15,
  parameter int REL_TICKS = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             sampleValid,
  input logic [ERR_W-1:0] phaseErr,
  input logic [2:0]       muxSel,
  input logic             locked,
  input logic             statusOut
);
  localparam logic [ERR_W:0] ACQ_LIM = ERR_W'(ACQ_TICKS);
  localparam logic [ERR_W:0] REL_LIM = ERR_W'(REL_TICKS);

  AST_RESET_UNLOCKED: assert property (@(posedge clk)
    rst |=> !locked);  // R1

  AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sampleValid) && ({1'b0, $past(phaseErr)} < ACQ_LIM));  // R4

  AST_BAD_BLOCKS_LOCK: assert property (@(posedge clk) disable iff (rst)
    !locked && sampleValid && ({1'b0, phaseErr} >= ACQ_LIM) |=> !locked);  // R6

  AST_DROP_ON_LARGE: assert property (@(posedge clk) disable iff (rst)
    locked && sampleValid && ({1'b0, phaseErr} > REL_LIM) |=> !locked);  // R5

  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (rst)
    locked && sampleValid && ({1'b0, phaseErr} <= REL_LIM) |=> locked);  // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(locked));  // R7

  AST_MUX_LOCK: assert property (@(posedge clk) disable iff (rst)
    (muxSel == 3'd1) |-> (statusOut == locked));  // R9
endmodule

bind pll_lock_detect pll_lock_detect_checker #(
  .ERR_W(ERR_W), .ACQ_TICKS(ACQ_TICKS), .REL_TICKS(REL_TICKS)
) uChk (
  .clk(clk), .rst(rst), .sampleValid(sampleValid), .phaseErr(phaseErr),
  .muxSel(muxSel), .locked(locked), .statusOut(statusOut)
);

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rst;
  logic sampleValid;
  logic [ERR_W-1:0] phaseErr;
  logic precise;
  logic [2:0] muxSel;
  logic refTick, fbTick;
  logic locked, statusOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_lock_detect uut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .phaseErr(phaseErr),
    .precise(precise), .muxSel(muxSel), .refTick(refTick), .fbTick(fbTick),
    .locked(locked), .statusOut(statusOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after the edge took the strobe
  task automatic strobe(input int e);
    sampleValid = 1'b1;
    phaseErr    = ERR_W'(e);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(input logic mode);
    rst = 1'b1; precise = mode; sampleValid = 1'b0; phaseErr = '0;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic testReset;
    doReset(1'b0);
    muxSel = 3'd1;
    check("R1 locked after reset", locked, 1'b0);
    muxSel = 3'd3; #0;
    check("R1 lastGood after reset", statusOut, 1'b0);
    muxSel = 3'd4; #0;
    check("R1 lastBad after reset", statusOut, 1'b0);
  endtask

  task automatic testFast;
    doReset(1'b0);
    strobe(3); strobe(14);
    check("R2 no lock after two good", locked, 1'b0);
    strobe(0);
    check("R2 lock on third good", locked, 1'b1);
  endtask

  task automatic testPrecise;
    doReset(1'b1);
    for (int i = 0; i < 4; i++) strobe(5);
    check("R3 no lock after four good", locked, 1'b0);
    strobe(5);
    check("R3 lock on fifth good", locked, 1'b1);
  endtask

  task automatic testThreshold;
    doReset(1'b0);
    strobe(14); strobe(14); strobe(15);
    check("R4 error equal to acquire limit is not good", locked, 1'b0);
    strobe(1); strobe(1);
    check("R6 run emptied by bad strobe", locked, 1'b0);
    strobe(1);
    check("R6 fresh run of three locks", locked, 1'b1);
  endtask

  task automatic testHysteresis;
    doReset(1'b0);
    strobe(2); strobe(2); strobe(2);
    strobe(20);
    check("R8 mid-band error keeps lock", locked, 1'b1);
    strobe(25);
    check("R5 error equal to release limit keeps lock", locked, 1'b1);
    strobe(26);
    check("R5 error above release limit drops lock", locked, 1'b0);
    strobe(2); strobe(2);
    check("R8 re-acquire needs full run", locked, 1'b0);
    strobe(2);
    check("R8 re-acquire completes", locked, 1'b1);
  endtask

  task automatic testIdle;
    doReset(1'b0);
    strobe(4); idle(3); strobe(4); idle(2);
    check("R7 idle does not count", locked, 1'b0);
    strobe(4);
    check("R7 idle does not break run", locked, 1'b1);
    idle(5);
    check("R7 idle keeps lock", locked, 1'b1);
  endtask

  task automatic testMux;
    doReset(1'b0);
    refTick = 1'b1; fbTick = 1'b0;
    strobe(30);
    muxSel = 3'd0; #0; check("R9 code 0", statusOut, 1'b0);
    muxSel = 3'd7; #0; check("R9 code 7", statusOut, 1'b1);
    muxSel = 3'd2; #0; check("R9 code 2 unlocked", statusOut, 1'b1);
    muxSel = 3'd4; #0; check("R10 lastBad set", statusOut, 1'b1);
    muxSel = 3'd3; #0; check("R10 lastGood clear", statusOut, 1'b0);
    muxSel = 3'd5; #0; check("R9 code 5 ref", statusOut, 1'b1);
    muxSel = 3'd6; #0; check("R9 code 6 fb", statusOut, 1'b0);
    refTick = 1'b0; fbTick = 1'b1;
    muxSel = 3'd5; #0; check("R9 code 5 ref low", statusOut, 1'b0);
    muxSel = 3'd6; #0; check("R9 code 6 fb high", statusOut, 1'b1);
    strobe(9); idle(2);
    muxSel = 3'd3; #0; check("R10 lastGood held", statusOut, 1'b1);
    muxSel = 3'd4; #0; check("R10 lastBad cleared", statusOut, 1'b0);
    strobe(9); strobe(9);
    muxSel = 3'd1; #0; check("R9 code 1 locked", statusOut, 1'b1);
    muxSel = 3'd2; #0; check("R9 code 2 locked", statusOut, 1'b0);
  endtask

  initial begin
    rst = 1'b1; sampleValid = 1'b0; phaseErr = '0; precise = 1'b0;
    muxSel = 3'd1; refTick = 1'b0; fbTick = 1'b0;
    @(negedge clk);
    testReset();
    testFast();
    testPrecise();
    testThreshold();
    testHysteresis();
    testIdle();
    testMux();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule